// File: doc/BRIEF.md
# Shared Bus Register File with Word Memory

This block is the register-and-memory datapath of a small accumulator machine. A single 16-bit bus connects six registers and a 4096 x 16 word memory. A 3-bit source code chooses which one of them drives the bus. Every register has its own load strobe. Most registers also have increment and clear strobes. On each rising clock edge, every register whose strobes are active updates at the same time. The instruction decoder and the sequencer sit outside the block and drive all of the strobes.

Two registers, the address register and the program counter, are 12 bits wide. Each of them occupies the low part of the bus, and its upper four bits are forced to zero. When either of them loads from the bus, it keeps only the low twelve bits. The accumulator never loads from the bus. It loads from a dedicated input port, which stands in for an arithmetic unit outside the block. The address register drives the memory address directly. A memory write stores the value on the bus. A memory read fills a registered read-data stage, and the bus can select that stage as a source.

Top module: `common_bus`

## Requirements
- R1: The bus carries the source selected by `bus_sel`: 0 gives all zeros, 1 the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register, 7 the memory read-data stage.
- R2: When the address register or the program counter drives the bus, bus bits 15..12 are zero and bits 11..0 hold the register.
- R3: When the address register or the program counter loads, it takes bus bits 11..0.
- R4: When a strobe vector bit is high (bit 0 address, 1 program counter, 2 data, 3 accumulator, 4 instruction, 5 temporary), the register captures the bus on the next rising edge. The exception is the accumulator, which captures `acc_in`.
- R5: An increment strobe adds one modulo the register width, so 0xFFF wraps to 0 and 0xFFFF wraps to 0. This applies to the address, program counter, data, accumulator and temporary registers.
- R6: A clear strobe sets the register to zero on the next rising edge.
- R7: When strobes combine on one register, clear wins over load, and load wins over increment.
- R8: The instruction register ignores its increment and clear strobe bits. It changes only on load.
- R9: `mem_wr` stores the current bus value at the address held in the address register on the rising edge.
- R10: `mem_rd` loads the word at the address register into the read-data stage on the rising edge. If a write happens in the same edge, the read returns the old word. The stage holds its value while `mem_rd` is low.
- R11: A synchronous active-high `rst` zeroes all registers and the read-data stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Bus source code |
| reg_ld | input | 6 | Per-register load strobes |
| reg_inc | input | 6 | Per-register increment strobes |
| reg_clr | input | 6 | Per-register clear strobes |
| mem_rd | input | 1 | Memory read into the read-data stage |
| mem_wr | input | 1 | Memory write of the bus value |
| acc_in | input | 16 | Load value for the accumulator |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |
| bus_q | output | 16 | Current bus value |

## Verification
The bench sweeps all eight source codes with accumulator patterns whose upper nibble is nonzero. This exposes a wrong source map and also any leak into bus bits 15..12 from the 12-bit registers.

Wrap-around values are used to separate correct increment widths from wrong ones. All eight combinations of clear, load and increment are applied to every register, including the instruction register, so that an inverted priority or a clear reaching that register becomes visible.

The whole memory is written through an incrementing address and then read back, which checks the address path and the latency of the read stage. A same-edge read and write separates read-first behaviour from write-first. A long pseudo-random run compares every output against an arithmetic model.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int NREG   = 6;

  localparam int IDX_AR = 0;
  localparam int IDX_PC = 1;
  localparam int IDX_DR = 2;
  localparam int IDX_AC = 3;
  localparam int IDX_IR = 4;
  localparam int IDX_TR = 5;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;
endpackage

// File: rtl/cbus_reg.sv
module cbus_reg #(
  parameter int W        = 16,
  parameter bit CAN_STEP = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         inc,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (CAN_STEP) begin : g_full
      // clear > load > increment
      always_ff @(posedge clk) begin
        if (rst || clr)   q <= '0;
        else if (ld)      q <= d;
        else if (inc)     q <= q + W'(1);
      end

      a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));
      a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> (q == $past(d)));
      a_r5_increment: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && !clr) |=> (q == $past(q) + W'(1)));
    end else begin : g_load_only
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ld) q <= d;
      end

      a_r8_no_step: assert property (@(posedge clk) disable iff (rst)
        (!ld && (inc || clr)) |=> $stable(q));
      a_r4_load: assert property (@(posedge clk) disable iff (rst)
        ld |=> (q == $past(d)));
    end
  endgenerate
endmodule

// File: rtl/cbus_mux.sv
module cbus_mux
  import cbus_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic [2:0]    sel,
  input  logic [AW-1:0] ar,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] dr,
  input  logic [DW-1:0] ac,
  input  logic [DW-1:0] ir,
  input  logic [DW-1:0] tr,
  input  logic [DW-1:0] mem,
  output logic [DW-1:0] bus
);
  localparam int PAD = DW - AW;

  always_comb begin
    unique case (bus_src_e'(sel))
      SRC_AR:  bus = {{PAD{1'b0}}, ar};
      SRC_PC:  bus = {{PAD{1'b0}}, pc};
      SRC_DR:  bus = dr;
      SRC_AC:  bus = ac;
      SRC_IR:  bus = ir;
      SRC_TR:  bus = tr;
      SRC_MEM: bus = mem;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/cbus_mem.sv
module cbus_mem #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // array write kept free of reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (wr) store[addr] <= wdata;
  end

  // read-first output register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= store[addr];
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/common_bus.sv
module common_bus
  import cbus_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    bus_sel,
  input  logic [NREG-1:0] reg_ld,
  input  logic [NREG-1:0] reg_inc,
  input  logic [NREG-1:0] reg_clr,
  input  logic          mem_rd,
  input  logic          mem_wr,
  input  logic [DW-1:0] acc_in,
  output logic [AW-1:0] ar_q,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] dr_q,
  output logic [DW-1:0] ac_q,
  output logic [DW-1:0] ir_q,
  output logic [DW-1:0] tr_q,
  output logic [DW-1:0] bus_q
);
  logic [DW-1:0] bus;
  logic [DW-1:0] mem_q;
  logic [AW-1:0] bus_lo;

  assign bus_lo = bus[AW-1:0];   // 12-bit registers keep the low bits
  assign bus_q  = bus;

  cbus_mux #(.DW(DW), .AW(AW)) u_mux (
    .sel(bus_sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
    .ir(ir_q), .tr(tr_q), .mem(mem_q), .bus(bus)
  );

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == SRC_NONE) |-> (bus_q == '0));
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ((bus_sel == SRC_AR) || (bus_sel == SRC_PC)) |-> (bus_q[DW-1:AW] == '0));

  cbus_reg #(.W(AW), .CAN_STEP(1'b1)) u_ar (
    .clk(clk), .rst(rst), .ld(reg_ld[IDX_AR]), .inc(reg_inc[IDX_AR]),
    .clr(reg_clr[IDX_AR]), .d(bus_lo), .q(ar_q)
  );

  cbus_reg #(.W(AW), .CAN_STEP(1'b1)) u_pc (
    .clk(clk), .rst(rst), .ld(reg_ld[IDX_PC]), .inc(reg_inc[IDX_PC]),
    .clr(reg_clr[IDX_PC]), .d(bus_lo), .q(pc_q)
  );

  cbus_reg #(.W(DW), .CAN_STEP(1'b1)) u_dr (
    .clk(clk), .rst(rst), .ld(reg_ld[IDX_DR]), .inc(reg_inc[IDX_DR]),
    .clr(reg_clr[IDX_DR]), .d(bus), .q(dr_q)
  );

  cbus_reg #(.W(DW), .CAN_STEP(1'b1)) u_ac (
    .clk(clk), .rst(rst), .ld(reg_ld[IDX_AC]), .inc(reg_inc[IDX_AC]),
    .clr(reg_clr[IDX_AC]), .d(acc_in), .q(ac_q)
  );

  cbus_reg #(.W(DW), .CAN_STEP(1'b0)) u_ir (
    .clk(clk), .rst(rst), .ld(reg_ld[IDX_IR]), .inc(reg_inc[IDX_IR]),
    .clr(reg_clr[IDX_IR]), .d(bus), .q(ir_q)
  );

  cbus_reg #(.W(DW), .CAN_STEP(1'b1)) u_tr (
    .clk(clk), .rst(rst), .ld(reg_ld[IDX_TR]), .inc(reg_inc[IDX_TR]),
    .clr(reg_clr[IDX_TR]), .d(bus), .q(tr_q)
  );

  cbus_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .rd(mem_rd), .wr(mem_wr),
    .addr(ar_q), .wdata(bus), .rdata(mem_q)
  );

  a_r11_reset: assert property (@(posedge clk)
    rst |=> (ar_q == '0 && pc_q == '0 && dr_q == '0 && ac_q == '0 &&
             ir_q == '0 && tr_q == '0));
endmodule

// File: tb/common_bus_tb.sv
module common_bus_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  bus_sel;
  logic [5:0]  reg_ld, reg_inc, reg_clr;
  logic        mem_rd, mem_wr;
  logic [15:0] acc_in;
  logic [11:0] ar_q, pc_q;
  logic [15:0] dr_q, ac_q, ir_q, tr_q, bus_q;

  always #5 clk = ~clk;

  common_bus u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .reg_ld(reg_ld),
    .reg_inc(reg_inc), .reg_clr(reg_clr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .acc_in(acc_in), .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q),
    .ir_q(ir_q), .tr_q(tr_q), .bus_q(bus_q)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [11:0] m_ar, m_pc;
  logic [15:0] m_dr, m_ac, m_ir, m_tr, m_mq;
  logic [15:0] m_mem [4096];

  function automatic logic [15:0] exp_bus(input logic [2:0] s);
    case (s)
      3'd1: return {4'h0, m_ar};
      3'd2: return {4'h0, m_pc};
      3'd3: return m_dr;
      3'd4: return m_ac;
      3'd5: return m_ir;
      3'd6: return m_tr;
      3'd7: return m_mq;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] nxt(input logic c, input logic l,
      input logic i, input logic [15:0] d, input logic [15:0] q);
    if (c) return 16'h0000;
    if (l) return d;
    if (i) return q + 16'h0001;
    return q;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_regs(input string tag);
    chk(tag, "ar", {4'h0, ar_q}, {4'h0, m_ar});
    chk(tag, "pc", {4'h0, pc_q}, {4'h0, m_pc});
    chk(tag, "dr", dr_q, m_dr);
    chk(tag, "ac", ac_q, m_ac);
    chk(tag, "ir", ir_q, m_ir);
    chk(tag, "tr", tr_q, m_tr);
  endtask

  // apply one cycle of controls, check bus before the edge and registers after
  task automatic step(input string tag, input logic [2:0] s, input logic [5:0] l,
      input logic [5:0] i, input logic [5:0] c, input logic rd, input logic wr,
      input logic [15:0] ext);
    logic [15:0] bv;
    logic [15:0] nq;
    bus_sel = s; reg_ld = l; reg_inc = i; reg_clr = c;
    mem_rd = rd; mem_wr = wr; acc_in = ext;
    #1;
    bv = exp_bus(s);
    chk(tag, "bus", bus_q, bv);
    nq = rd ? m_mem[m_ar] : m_mq;
    if (wr) m_mem[m_ar] = bv;
    m_mq = nq;
    m_ar = nxt(c[0], l[0], i[0], {4'h0, bv[11:0]}, {4'h0, m_ar})[11:0];
    m_pc = nxt(c[1], l[1], i[1], {4'h0, bv[11:0]}, {4'h0, m_pc})[11:0];
    m_dr = nxt(c[2], l[2], i[2], bv, m_dr);
    m_ac = nxt(c[3], l[3], i[3], ext, m_ac);
    m_ir = l[4] ? bv : m_ir;
    m_tr = nxt(c[5], l[5], i[5], bv, m_tr);
    @(posedge clk); #1;
    compare_regs(tag);
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [15:0] pats [6];
    pats[0] = 16'hF5A3; pats[1] = 16'hFFFF; pats[2] = 16'h8001;
    pats[3] = 16'h0F0F; pats[4] = 16'hA000; pats[5] = 16'h7FFE;
    rst = 1'b1; bus_sel = 3'd0; reg_ld = '0; reg_inc = '0; reg_clr = '0;
    mem_rd = 1'b0; mem_wr = 1'b0; acc_in = 16'h0;
    m_ar = '0; m_pc = '0; m_dr = '0; m_ac = '0; m_ir = '0; m_tr = '0; m_mq = '0;
    for (int k = 0; k < 4096; k++) m_mem[k] = 16'h0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    // R11 reset state
    compare_regs("R11");
    chk("R11", "bus", bus_q, 16'h0000);

    // R1 R2 R3 R4: source sweep with several patterns
    foreach (pats[p]) begin
      step("R4", 3'd0, 6'b001000, '0, '0, 1'b0, 1'b0, pats[p]);
      step("R3", 3'd4, 6'b110111, '0, '0, 1'b0, 1'b0, 16'h0);
      step("R4", 3'd0, 6'b001000, '0, '0, 1'b0, 1'b0, ~pats[p]);
      for (int s = 0; s < 8; s++)
        step("R1", 3'(s), '0, '0, '0, 1'b0, 1'b0, 16'h0);
      step("R2", 3'd1, 6'b100100, '0, '0, 1'b0, 1'b0, 16'h0);
      step("R2", 3'd2, 6'b010100, '0, '0, 1'b0, 1'b0, 16'h0);
      for (int s = 1; s < 8; s++)
        step("R4", 3'(s), 6'b110111, '0, '0, 1'b0, 1'b0, 16'h0);
    end

    // R5 increment wrap
    step("R5", 3'd0, 6'b001000, '0, '0, 1'b0, 1'b0, 16'hFFFF);
    step("R5", 3'd4, 6'b110111, '0, '0, 1'b0, 1'b0, 16'h0);
    for (int n = 0; n < 3; n++)
      step("R5", 3'd0, '0, 6'b111111, '0, 1'b0, 1'b0, 16'h0);
    // R8 IR ignores inc and clr
    step("R8", 3'd0, '0, 6'b010000, 6'b010000, 1'b0, 1'b0, 16'h0);
    // R6 clear
    step("R6", 3'd0, '0, '0, 6'b111111, 1'b0, 1'b0, 16'h0);

    // R7 priority: all combinations on all registers
    for (int combo = 0; combo < 8; combo++) begin
      step("R7", 3'd0, 6'b001000, '0, '0, 1'b0, 1'b0, 16'hC3A5);
      step("R7", 3'd4, 6'b110111, '0, '0, 1'b0, 1'b0, 16'h0);
      step("R7", 3'd3, {6{combo[1]}}, {6{combo[0]}}, {6{combo[2]}},
           1'b0, 1'b0, 16'h1E2D);
    end

    // R9 write every word through an incrementing address
    step("R9", 3'd0, 6'b001000, '0, 6'b000001, 1'b0, 1'b0, 16'h5A5A);
    for (int k = 0; k < 4096; k++)
      step("R9", 3'd4, 6'b001000, 6'b000001, '0, 1'b0, 1'b1,
           16'((k + 1) * 40503) ^ 16'h5A5A);
    // R10 read back, data register captures the stage one cycle later
    step("R10", 3'd0, '0, '0, 6'b000001, 1'b0, 1'b0, 16'h0);
    for (int k = 0; k < 4096; k++)
      step("R10", 3'd7, 6'b000100, 6'b000001, '0, 1'b1, 1'b0, 16'h0);
    // R10 hold with mem_rd low, then read-first on same-edge write
    step("R10", 3'd7, '0, 6'b000001, '0, 1'b0, 1'b0, 16'h0);
    step("R10", 3'd7, '0, '0, '0, 1'b0, 1'b0, 16'h0);
    step("R10", 3'd0, 6'b001000, '0, '0, 1'b0, 1'b0, 16'hBEEF);
    step("R10", 3'd4, '0, '0, '0, 1'b1, 1'b1, 16'h0);
    step("R10", 3'd7, '0, '0, '0, 1'b1, 1'b0, 16'h0);
    step("R9", 3'd7, '0, '0, '0, 1'b0, 1'b0, 16'h0);

    // mixed pseudo-random traffic
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 3000; n++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      step("R4", lfsr[2:0], lfsr[8:3], lfsr[14:9],
           lfsr[20:15] & {6{lfsr[21]}}, lfsr[22], lfsr[23] & lfsr[24],
           lfsr[31:16] ^ 16'(n));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule